// File: doc/BRIEF.md
# Mode-Selectable Synthesizer Divider and Phase Comparator

This block is the digital heart of a frequency synthesizer. A reference divider turns the crystal clock into a comparison tick. The tick's period depends on a 2-bit operating mode. A programmable divider counts prescaled RF pulses and emits one feedback tick for every N of them. N is a divisor loaded through a strobe, and the mode decides whether it is 14 or 15 bits wide. A two-state phase/frequency comparator drives up and down pump requests from the two tick streams. A lock detector watches the pump pulse widths and reports lock on an active-low output-enable.

Everything runs on the crystal clock. The prescaled RF signal arrives as a one-cycle pulse that is already synchronous to that clock. Pump pulse widths are therefore measured in crystal cycles. The widest pulse that still counts as "in lock" is set at a port. With a 4 MHz crystal the tick rates are 7.8125, 3.90625 and 6.25 kHz, and the synthesized frequency is 16 × N × the comparison rate.

Top module: `synth_core`

## Requirements
- R1: `ref_out` is a one-cycle pulse repeating every 512 clocks in mode 3 and mode 2, every 1024 clocks in mode 1 and every 640 clocks in mode 0; a new mode applies from the next reload of the reference counter.
- R2: A divisor loaded while the mode is 3 keeps only its bits 13:0; in modes 0, 1 and 2 all 15 bits are kept.
- R3: `fb_out` pulses for one cycle, in the cycle after every N-th accepted `rf_pulse`, where N is the loaded divisor; divisors 0 and 1 behave as 2. After reset the first `rf_pulse` produces a tick.
- R4: A divisor loaded partway through a count does not change that count; it applies from the next reload.
- R5: `pump_up` rises in the cycle after a `ref_out` pulse and `pump_dn` rises in the cycle after an `fb_out` pulse. Once both would be set, both clear, so the two are never high together. When feedback runs faster than reference, only `pump_dn` is driven.
- R6: `lock_oe` goes low (locked) only at a reference tick that ends the 8th consecutive reference period in which no pump pulse lasted more than `max_width` cycles.
- R7: `lock_oe` returns high in the cycle after any pump pulse exceeds `max_width` cycles. Lock then needs 8 fresh clean periods.
- R8: During reset `ref_out`, `fb_out`, `pump_up` and `pump_dn` are low and `lock_oe` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Operating mode: reference ratio and divisor width |
| divisor_in | input | 15 | Divisor value for the feedback divider |
| divisor_load | input | 1 | One-cycle strobe capturing `divisor_in` |
| rf_pulse | input | 1 | One-cycle pulse per prescaled RF period |
| max_width | input | 4 | Longest pump pulse, in clocks, tolerated in lock |
| ref_out | output | 1 | Comparison tick |
| fb_out | output | 1 | Divided feedback tick |
| pump_up | output | 1 | Up request to the charge pump |
| pump_dn | output | 1 | Down request to the charge pump |
| lock_oe | output | 1 | Lock pin enable: high drives low (unlocked), low releases (locked) |

## Verification
The bench sweeps small divisors under three RF pulse densities, including the degenerate values 0 and 1. A divider with an off-by-one reload, or one that skips the clamp, gives intervals one pulse too long or stalls. It loads a divisor mid-count to catch a design that reloads at once and corrupts the interval in flight. It also loads bit 14 in the 14-bit mode, where a missing mask stretches the interval by 16384 pulses. The lock sequence counts ticks exactly. It shows that lock does not come early, that a zero tolerance drops lock one cycle after the pump pulse, and that a feedback frequency 2% high keeps the loop unlocked with only down pulses.

// File: rtl/synth_core_pkg.sv
package synth_core_pkg;

  localparam int REF_W = 11;
  localparam int DIV_W = 15;

  typedef enum logic [1:0] {
    SM_STEP100   = 2'd0,
    SM_STEP62    = 2'd1,
    SM_WIDE125   = 2'd2,
    SM_NARROW125 = 2'd3
  } synth_mode_e;

  function automatic logic [REF_W-1:0] ref_ratio(input logic [1:0] m);
    case (synth_mode_e'(m))
      SM_STEP100:   return REF_W'(640);
      SM_STEP62:    return REF_W'(1024);
      default:      return REF_W'(512);
    endcase
  endfunction

  function automatic logic [DIV_W-1:0] div_mask(input logic [1:0] m);
    return (synth_mode_e'(m) == SM_NARROW125) ? DIV_W'(16'h3FFF) : DIV_W'(16'h7FFF);
  endfunction

  function automatic logic [DIV_W-1:0] div_effective(input logic [DIV_W-1:0] n);
    return (n < DIV_W'(2)) ? DIV_W'(2) : n;
  endfunction

endpackage

// File: rtl/ref_divider.sv
module ref_divider
  import synth_core_pkg::*;
#(
  parameter int CNT_W = REF_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  output logic       ref_tick
);
  logic [CNT_W-1:0] cnt_q;
  logic             reload;

  assign reload = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      ref_tick <= 1'b0;
    end else if (reload) begin
      cnt_q    <= CNT_W'(ref_ratio(mode)) - CNT_W'(1);
      ref_tick <= 1'b1;
    end else begin
      cnt_q    <= cnt_q - CNT_W'(1);
      ref_tick <= 1'b0;
    end
  end
endmodule

// File: rtl/prog_divider.sv
module prog_divider
  import synth_core_pkg::*;
#(
  parameter int W = DIV_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode,
  input  logic [W-1:0] divisor_in,
  input  logic         divisor_load,
  input  logic         rf_pulse,
  output logic         fb_tick
);
  logic [W-1:0] pending_q;
  logic [W-1:0] cnt_q;
  logic         terminal;

  assign terminal = rf_pulse && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= '0;
    end else if (divisor_load) begin
      pending_q <= divisor_in & W'(div_mask(mode));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fb_tick <= 1'b0;
    end else begin
      fb_tick <= terminal;
      if (terminal)      cnt_q <= W'(div_effective(DIV_W'(pending_q))) - W'(1);
      else if (rf_pulse) cnt_q <= cnt_q - W'(1);
    end
  end
endmodule

// File: rtl/phase_comparator.sv
module phase_comparator (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic fb_tick,
  output logic pump_up,
  output logic pump_dn
);
  logic [1:0] trig;
  logic [1:0] state_q;
  logic [1:0] would_set;
  logic       clear_both;

  assign trig       = {fb_tick, ref_tick};
  assign clear_both = &would_set;

  for (genvar i = 0; i < 2; i++) begin : g_side
    assign would_set[i] = state_q[i] | trig[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q[i] <= 1'b0;
      else        state_q[i] <= would_set[i] & ~clear_both;
    end
  end

  assign pump_up = state_q[0];
  assign pump_dn = state_q[1];
endmodule

// File: rtl/lock_detector.sv
module lock_detector #(
  parameter int LOCK_PERIODS = 8,
  parameter int WIN_W        = 4,
  localparam int GOOD_W      = $clog2(LOCK_PERIODS + 1),
  localparam int WCNT_W      = WIN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic             pump_up,
  input  logic             pump_dn,
  input  logic [WIN_W-1:0] max_width,
  output logic             violation,
  output logic             locked
);
  logic [WCNT_W-1:0] wcnt_q;
  logic [GOOD_W-1:0] good_q;
  logic [GOOD_W-1:0] good_inc;
  logic              bad_q;
  logic              active;

  assign active    = pump_up | pump_dn;
  assign violation = active && (wcnt_q >= WCNT_W'(max_width));
  assign good_inc  = (good_q == GOOD_W'(LOCK_PERIODS)) ? good_q : good_q + GOOD_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q <= '0;
    end else if (!active) begin
      wcnt_q <= '0;
    end else if (wcnt_q != '1) begin
      wcnt_q <= wcnt_q + WCNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_q <= '0;
      bad_q  <= 1'b0;
      locked <= 1'b0;
    end else if (ref_tick) begin
      bad_q <= 1'b0;
      if (bad_q || violation) begin
        good_q <= '0;
        locked <= 1'b0;
      end else begin
        good_q <= good_inc;
        locked <= (good_inc == GOOD_W'(LOCK_PERIODS));
      end
    end else if (violation) begin
      good_q <= '0;
      bad_q  <= 1'b1;
      locked <= 1'b0;
    end
  end
endmodule

// File: rtl/synth_core.sv
module synth_core
  import synth_core_pkg::*;
#(
  parameter int LOCK_PERIODS = 8,
  parameter int WIN_W        = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [DIV_W-1:0] divisor_in,
  input  logic             divisor_load,
  input  logic             rf_pulse,
  input  logic [WIN_W-1:0] max_width,
  output logic             ref_out,
  output logic             fb_out,
  output logic             pump_up,
  output logic             pump_dn,
  output logic             lock_oe
);
  logic width_violation;
  logic locked;

  ref_divider #(.CNT_W(REF_W)) u_ref (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .ref_tick (ref_out)
  );

  prog_divider #(.W(DIV_W)) u_fb (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode         (mode),
    .divisor_in   (divisor_in),
    .divisor_load (divisor_load),
    .rf_pulse     (rf_pulse),
    .fb_tick      (fb_out)
  );

  phase_comparator u_pfd (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_tick (ref_out),
    .fb_tick  (fb_out),
    .pump_up  (pump_up),
    .pump_dn  (pump_dn)
  );

  lock_detector #(.LOCK_PERIODS(LOCK_PERIODS), .WIN_W(WIN_W)) u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_tick  (ref_out),
    .pump_up   (pump_up),
    .pump_dn   (pump_dn),
    .max_width (max_width),
    .violation (width_violation),
    .locked    (locked)
  );

  assign lock_oe = ~locked;
endmodule

// File: rtl/synth_core_checker.sv
module synth_core_checker (
  input logic clk,
  input logic rst_n,
  input logic rf_pulse,
  input logic ref_out,
  input logic fb_out,
  input logic pump_up,
  input logic pump_dn,
  input logic lock_oe,
  input logic width_violation
);
  assert_ref_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ref_out |=> !ref_out);

  assert_fb_needs_rf_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fb_out |-> $past(rf_pulse));

  assert_pumps_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(pump_up && pump_dn));

  assert_up_after_ref_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pump_up) |-> $past(ref_out));

  assert_dn_after_fb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pump_dn) |-> $past(fb_out));

  assert_lock_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_oe) |-> $past(ref_out));

  assert_drop_on_viol_R7: assert property (@(posedge clk) disable iff (!rst_n)
    width_violation |=> lock_oe);
endmodule

bind synth_core synth_core_checker u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .rf_pulse        (rf_pulse),
  .ref_out         (ref_out),
  .fb_out          (fb_out),
  .pump_up         (pump_up),
  .pump_dn         (pump_dn),
  .lock_oe         (lock_oe),
  .width_violation (width_violation)
);

// File: tb/tb_synth_core.sv
module tb_synth_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'd3;
  logic [14:0] divisor_in = '0;
  logic        divisor_load = 1'b0;
  logic        rf_pulse = 1'b0;
  logic [3:0]  max_width = 4'd4;
  logic        ref_out, fb_out, pump_up, pump_dn, lock_oe;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  synth_core dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .divisor_in(divisor_in),
    .divisor_load(divisor_load), .rf_pulse(rf_pulse), .max_width(max_width),
    .ref_out(ref_out), .fb_out(fb_out), .pump_up(pump_up), .pump_dn(pump_dn),
    .lock_oe(lock_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_len(input int m);
    return (m == 1) ? 1024 : (m == 0) ? 640 : 512;
  endfunction

  function automatic int eff_div(input int m, input int raw);
    int v = (m == 3) ? (raw % 16384) : (raw % 32768);
    return (v < 2) ? 2 : v;
  endfunction

  function automatic bit pat_bit(input int pat, input int c);
    case (pat)
      0: return 1'b1;
      1: return (c % 3) == 0;
      default: return ((c % 5) == 0) || ((c % 5) == 2);
    endcase
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    rf_pulse = 1'b0;
    divisor_load = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_ref(output int len);
    len = 0;
    do begin
      @(negedge clk);
      len++;
    end while (!ref_out);
  endtask

  task automatic wait_ticks(input int n);
    int d;
    for (int i = 0; i < n; i++) wait_ref(d);
  endtask

  task automatic fb_interval(input int pat, input int load_at, input int load_val,
                             output int pulses);
    bit seen;
    pulses = 0;
    do begin
      @(negedge clk);
      if (rf_pulse) pulses++;
      seen = fb_out;
      divisor_load = (!seen && pulses == load_at);
      divisor_in = 15'(load_val);
      rf_pulse = pat_bit(pat, cyc);
      cyc++;
    end while (!seen);
    divisor_load = 1'b0;
  endtask

  task automatic load_div(input int v);
    @(negedge clk);
    divisor_in = 15'(v);
    divisor_load = 1'b1;
    @(negedge clk);
    divisor_load = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int len, x, upc, dnc;
    bit prev_up, drop_ok;

    // R8: reset state
    @(negedge clk);
    check(!ref_out && !fb_out && !pump_up && !pump_dn, "R8 outputs low in reset",
          int'({ref_out, fb_out, pump_up, pump_dn}), 0);
    check(lock_oe == 1'b1, "R8 lock_oe high in reset", lock_oe, 1);
    rst_n = 1'b1;

    // R1: reference period per mode
    for (int m = 3; m >= 0; m--) begin
      mode = 2'(m);
      wait_ref(len);
      wait_ref(len);
      wait_ref(len);
      check(len == ref_len(m), $sformatf("R1 ref period mode %0d", m), len, ref_len(m));
    end

    // R3: divisor sweep under three RF densities
    mode = 2'd2;
    for (int pat = 0; pat < 3; pat++) begin
      for (int n = 0; n <= 13; n++) begin
        load_div(n);
        fb_interval(pat, -1, 0, x);
        fb_interval(pat, -1, 0, x);
        check(x == eff_div(2, n), $sformatf("R3 interval N=%0d pat=%0d", n, pat), x, eff_div(2, n));
      end
      load_div(100);
      fb_interval(pat, -1, 0, x);
      fb_interval(pat, -1, 0, x);
      check(x == 100, $sformatf("R3 interval N=100 pat=%0d", pat), x, 100);
    end

    // R4: load mid-count, old count completes first
    load_div(9);
    fb_interval(2, -1, 0, x);
    fb_interval(2, 3, 4, x);
    check(x == 9, "R4 in-flight interval keeps old divisor", x, 9);
    fb_interval(2, -1, 0, x);
    check(x == 4, "R4 new divisor after reload", x, 4);

    // R2: width masking per mode
    mode = 2'd3;
    load_div(16'h4007);
    fb_interval(0, -1, 0, x);
    fb_interval(0, -1, 0, x);
    check(x == 7, "R2 mode 3 drops bit 14", x, 7);
    load_div(16'h4000);
    fb_interval(0, -1, 0, x);
    fb_interval(0, -1, 0, x);
    check(x == 2, "R2 mode 3 masked zero behaves as 2", x, 2);
    mode = 2'd0;
    load_div(16'h4003);
    fb_interval(0, -1, 0, x);
    fb_interval(0, -1, 0, x);
    check(x == 16387, "R2 mode 0 keeps 15 bits", x, 16387);

    // R5/R6: aligned lock sequence, mode 3, divisor 512
    do_reset();
    mode = 2'd3;
    max_width = 4'd4;
    divisor_in = 15'd512;
    divisor_load = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);
    divisor_load = 1'b0;
    check(ref_out && !pump_up, "R5 ref tick before up", int'({ref_out, pump_up}), 2);
    rf_pulse = 1'b1;
    @(negedge clk);
    check(pump_up && !pump_dn && fb_out, "R5 up rises after ref tick",
          int'({pump_up, pump_dn, fb_out}), 5);
    @(negedge clk);
    check(!pump_up && !pump_dn, "R5 both clear once both set",
          int'({pump_up, pump_dn}), 0);
    wait_ticks(5);
    check(lock_oe == 1'b1, "R6 not locked before 8 clean periods", lock_oe, 1);
    wait_ticks(4);
    check(lock_oe == 1'b0, "R6 locked after 8 clean periods", lock_oe, 0);

    // R7: zero tolerance drops lock the cycle after a pump pulse
    max_width = 4'd0;
    prev_up = 1'b0;
    drop_ok = 1'b0;
    len = 0;
    do begin
      @(negedge clk);
      len++;
      if (lock_oe) drop_ok = prev_up;
      prev_up = pump_up;
    end while (!lock_oe && len < 2000);
    check(drop_ok && lock_oe, "R7 lock drops cycle after wide pulse", int'({drop_ok, lock_oe}), 3);
    max_width = 4'd4;
    wait_ticks(4);
    check(lock_oe == 1'b1, "R7 relock needs fresh periods", lock_oe, 1);
    wait_ticks(8);
    check(lock_oe == 1'b0, "R7 relocked after clean periods", lock_oe, 0);

    // R5/R6: feedback too fast -> only down pulses, no lock
    load_div(500);
    wait_ticks(3);
    upc = 0;
    dnc = 0;
    for (int i = 0; i < 5; i++) begin
      do begin
        @(negedge clk);
        upc += int'(pump_up);
        dnc += int'(pump_dn);
      end while (!ref_out);
    end
    check(dnc > 0 && upc == 0, "R5 fast feedback gives only down pulses", upc, 0);
    wait_ticks(12);
    check(lock_oe == 1'b1, "R6 no lock with frequency error", lock_oe, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule